// File: doc/BRIEF.md
# Three-Valued Test Cube Compactor

The block shrinks a stream of partially specified test vectors ("cubes") before they are stored. Each cube covers `NPI` input positions. Each position is 0, 1 or don't-care. The block holds a table of up to `DEPTH` merged cubes. Each arriving cube is compared with the stored entries in index order. The cube is folded into the first entry that has no clashing specified position. If no entry fits, the cube takes the next free slot. If no entry fits and the table is full, the cube is refused and a sticky overflow flag is set.

Position `i` of a cube sits at bits `[2i+1:2i]`. The codes are `00` = don't-care, `10` = 0 and `11` = 1. The code `01` is read as don't-care. The upper bit of a position marks it as specified, and the lower bit is its value.

A controller state machine drives the block. It has five states:

- `ST_IDLE` has `in_ready` high. Transition *accept* goes to `ST_SCAN`. Transition *first* goes straight to `ST_ALLOC` when the table is empty.
- `ST_SCAN` tests one stored entry per cycle. Transition *hit* goes to `ST_MERGE`. Transition *step* stays in `ST_SCAN` and moves to the next entry. Transition *miss* goes to `ST_ALLOC`. Transition *full* goes to `ST_REJECT`.
- `ST_MERGE`, `ST_ALLOC` and `ST_REJECT` each last one cycle. Each reports its result on `res_*` and then takes transition *done* back to `ST_IDLE`.

The table can be read at any time through `rd_idx`/`rd_cube`, and `count` gives the number of used entries.

Top module: `cube_compactor`

## Requirements
- R1: After reset, `count` is 0, `ovf` is 0, `in_ready` is 1, `res_valid` is 0, and every read slot returns all don't-care (`00` in every position).
- R2: A merge stores the position-wise intersection. Don't-care with v gives v, 0 with 0 gives 0, and 1 with 1 gives 1. A 0 against a 1 is a conflict, which makes the pair incompatible. A position that is don't-care in both cubes stays don't-care.
- R3: A cube compatible with several stored entries is merged into the lowest-index one only. `res_merged` pulses with `res_idx` equal to that index, and `count` does not change.
- R4: A cube compatible with no entry, while `count < DEPTH`, is stored unchanged at index `count`. `count` then rises by one, and `res_valid` pulses with `res_merged` and `res_reject` both low.
- R5: A cube compatible with no entry, while `count == DEPTH`, is refused. `res_reject` pulses, `ovf` goes high and stays high until reset, and neither `count` nor any stored entry changes.
- R6: A cube is taken only on a cycle with `in_valid` and `in_ready` both high. `in_ready` stays low from acceptance until the result cycle ends, and `in_cube`/`in_valid` have no effect during that time.
- R7: Counting clock edges after the accepting edge, `res_valid` is high after j+1 edges for a hit at index j. For a miss or a refusal with c entries stored, it is high after c edges, which is 0 edges when c is 0. It lasts exactly one cycle.
- R8: `rd_cube` returns the stored entry at `rd_idx` when `rd_idx < count`, and all don't-care otherwise. A write is visible there from the cycle after the result cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming cube is valid |
| in_ready | output | 1 | Block can take a cube |
| in_cube | input | 2*NPI | Incoming cube, 2 bits per position |
| res_valid | output | 1 | One-cycle result strobe for the accepted cube |
| res_merged | output | 1 | Cube was merged into an existing entry |
| res_reject | output | 1 | Cube was refused (table full, no fit) |
| res_idx | output | IW | Entry written (merged or newly allocated) |
| count | output | CW | Number of used entries |
| ovf | output | 1 | Sticky overflow flag |
| rd_idx | input | IW | Readout slot index |
| rd_cube | output | 2*NPI | Cube stored at `rd_idx`, don't-care if unused |

## Verification
The hardest case to reach is the end of a full table, where only the last entry's answer decides the outcome. If the last entry conflicts, the cube is refused. If it fits, the cube is merged. To reach this case, the stimulus table builds up entries whose specified positions clash pairwise. It then sends one cube that clashes with all of them, and after that one cube that fits only the last slot. Along the way it sends a cube that fits two entries, to show that the lower index wins. During every scan, a different cube is held on `in_cube` with `in_valid` high, which shows that input is ignored while the block is busy.

// File: rtl/cubecmp_pkg.sv
package cubecmp_pkg;

    // Two-bit position code: upper bit = specified, lower bit = value
    localparam logic [1:0] POS_X   = 2'b00;
    localparam logic [1:0] POS_ZERO = 2'b10;
    localparam logic [1:0] POS_ONE  = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SCAN   = 3'd1,
        ST_MERGE  = 3'd2,
        ST_ALLOC  = 3'd3,
        ST_REJECT = 3'd4
    } cc_state_e;

endpackage

// File: rtl/cubecmp_isect.sv
module cubecmp_isect #(
    parameter int NPI = 8,
    localparam int W = 2 * NPI
) (
    input  logic [W-1:0] a_cube,
    input  logic [W-1:0] b_cube,
    output logic [W-1:0] y_cube,
    output logic         conflict
);
    import cubecmp_pkg::*;

    logic [NPI-1:0] clash;

    for (genvar i = 0; i < NPI; i++) begin : g_pos
        logic a_spec;
        logic b_spec;
        assign a_spec = a_cube[2*i+1];
        assign b_spec = b_cube[2*i+1];
        assign clash[i] = a_spec && b_spec && (a_cube[2*i] != b_cube[2*i]);
        always_comb begin
            if (a_spec)
                y_cube[2*i+1 -: 2] = a_cube[2*i] ? POS_ONE : POS_ZERO;
            else if (b_spec)
                y_cube[2*i+1 -: 2] = b_cube[2*i] ? POS_ONE : POS_ZERO;
            else
                y_cube[2*i+1 -: 2] = POS_X;
        end
    end

    assign conflict = |clash;

endmodule

// File: rtl/cubecmp_store.sv
module cubecmp_store #(
    parameter int NPI   = 8,
    parameter int DEPTH = 4,
    localparam int W    = 2 * NPI,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int SLOTS = 1 << IW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] scan_idx,
    output logic [W-1:0]  scan_cube,
    input  logic [IW-1:0] rd_idx,
    input  logic [CW-1:0] used,
    output logic [W-1:0]  rd_cube
);

    logic [W-1:0] slot_q [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[s] <= '0;
            else if (we && (widx == IW'(s)) && (s < DEPTH))
                slot_q[s] <= wdata;
        end
    end

    assign scan_cube = slot_q[scan_idx];

    always_comb begin
        if (CW'(rd_idx) < used)
            rd_cube = slot_q[rd_idx];
        else
            rd_cube = '0;
    end

endmodule

// File: rtl/cubecmp_ctrl.sv
module cubecmp_ctrl #(
    parameter int NPI   = 8,
    parameter int DEPTH = 4,
    localparam int W    = 2 * NPI,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [W-1:0]  in_cube,
    output logic          in_ready,
    output logic [W-1:0]  cube_q,
    output logic [IW-1:0] scan_idx,
    input  logic          conflict,
    output logic          we,
    output logic [IW-1:0] widx,
    output logic          use_blank,
    output logic [CW-1:0] count,
    output logic          ovf,
    output logic          res_valid,
    output logic          res_merged,
    output logic          res_reject,
    output logic [IW-1:0] res_idx
);
    import cubecmp_pkg::*;

    cc_state_e state, nxt;
    logic      at_last;
    logic      tbl_full;

    assign at_last  = (CW'(scan_idx) == (count - CW'(1)));
    assign tbl_full = (count == CW'(DEPTH));

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (in_valid)
                    nxt = (count == '0) ? ST_ALLOC : ST_SCAN;
            end
            ST_SCAN: begin
                if (!conflict)
                    nxt = ST_MERGE;
                else if (at_last)
                    nxt = tbl_full ? ST_REJECT : ST_ALLOC;
            end
            ST_MERGE, ST_ALLOC, ST_REJECT: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            scan_idx <= '0;
            count    <= '0;
            ovf      <= 1'b0;
            cube_q   <= '0;
        end else begin
            state <= nxt;
            unique case (state)
                ST_IDLE: begin
                    if (in_valid) begin
                        cube_q   <= in_cube;
                        scan_idx <= '0;
                    end
                end
                ST_SCAN: begin
                    if (conflict && !at_last)
                        scan_idx <= scan_idx + IW'(1);
                end
                ST_ALLOC:  count <= count + CW'(1);
                ST_REJECT: ovf <= 1'b1;
                default: ;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        in_ready   = 1'b0;
        we         = 1'b0;
        use_blank  = 1'b0;
        res_valid  = 1'b0;
        res_merged = 1'b0;
        res_reject = 1'b0;
        widx       = scan_idx;
        unique case (state)
            ST_IDLE:  in_ready = 1'b1;
            ST_SCAN:  ;
            ST_MERGE: begin
                we         = 1'b1;
                res_valid  = 1'b1;
                res_merged = 1'b1;
            end
            ST_ALLOC: begin
                we        = 1'b1;
                use_blank = 1'b1;
                res_valid = 1'b1;
                widx      = IW'(count);
            end
            ST_REJECT: begin
                res_valid  = 1'b1;
                res_reject = 1'b1;
            end
            default: ;
        endcase
        res_idx = widx;
    end

endmodule

// File: rtl/cube_compactor.sv
module cube_compactor #(
    parameter int NPI   = 8,
    parameter int DEPTH = 4,
    localparam int W    = 2 * NPI,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [W-1:0]  in_cube,
    output logic          res_valid,
    output logic          res_merged,
    output logic          res_reject,
    output logic [IW-1:0] res_idx,
    output logic [CW-1:0] count,
    output logic          ovf,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_cube
);

    logic [W-1:0]  cube_q;
    logic [W-1:0]  scan_cube;
    logic [W-1:0]  other_cube;
    logic [W-1:0]  merged_cube;
    logic [IW-1:0] scan_idx;
    logic [IW-1:0] widx;
    logic          conflict;
    logic          we;
    logic          use_blank;

    cubecmp_ctrl #(.NPI(NPI), .DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_cube    (in_cube),
        .in_ready   (in_ready),
        .cube_q     (cube_q),
        .scan_idx   (scan_idx),
        .conflict   (conflict),
        .we         (we),
        .widx       (widx),
        .use_blank  (use_blank),
        .count      (count),
        .ovf        (ovf),
        .res_valid  (res_valid),
        .res_merged (res_merged),
        .res_reject (res_reject),
        .res_idx    (res_idx)
    );

    // a blank partner turns the intersection into a plain normalising copy
    assign other_cube = use_blank ? '0 : scan_cube;

    cubecmp_isect #(.NPI(NPI)) u_isect (
        .a_cube   (cube_q),
        .b_cube   (other_cube),
        .y_cube   (merged_cube),
        .conflict (conflict)
    );

    cubecmp_store #(.NPI(NPI), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (we),
        .widx      (widx),
        .wdata     (merged_cube),
        .scan_idx  (scan_idx),
        .scan_cube (scan_cube),
        .rd_idx    (rd_idx),
        .used      (count),
        .rd_cube   (rd_cube)
    );

endmodule

// File: rtl/cube_compactor_chk.sv
module cube_compactor_chk #(
    parameter int NPI   = 8,
    parameter int DEPTH = 4,
    localparam int W    = 2 * NPI,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          res_valid,
    input logic          res_merged,
    input logic          res_reject,
    input logic [IW-1:0] res_idx,
    input logic [CW-1:0] count,
    input logic          ovf
);

    // R6
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R5
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    // R5
    reject_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_reject) |-> (count == CW'(DEPTH)));

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count == $past(count)) || (count == $past(count) + CW'(1)));

    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R7
    res_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R3
    merge_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_merged) |-> (CW'(res_idx) < count));

    // R6
    ready_not_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !in_ready);

endmodule

bind cube_compactor cube_compactor_chk #(.NPI(NPI), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .res_valid  (res_valid),
    .res_merged (res_merged),
    .res_reject (res_reject),
    .res_idx    (res_idx),
    .count      (count),
    .ovf        (ovf)
);

// File: tb/cube_compactor_bench.sv
`timescale 1ns/1ps
module cube_compactor_bench;

    localparam int NPI   = 4;
    localparam int DEPTH = 3;
    localparam int W     = 2 * NPI;
    localparam int IW    = 2;
    localparam int CW    = 2;
    localparam int NV    = 8;

    // kinds: 0 = new entry, 1 = merged, 2 = refused
    localparam logic [31:0] T_CUBE [NV] = '{"01XX", "0X0X", "1XXX", "X11X",
                                            "XXX1", "0X1X", "1000", "X0XX"};
    localparam int          T_KIND [NV] = '{0, 1, 0, 1, 1, 0, 2, 1};
    localparam int          T_IDX  [NV] = '{0, 0, 1, 1, 0, 2, 0, 2};
    localparam int          T_LAT  [NV] = '{0, 1, 1, 2, 1, 2, 3, 3};
    localparam logic [31:0] T_ENT  [NV] = '{"01XX", "010X", "1XXX", "111X",
                                            "0101", "0X1X", "0101", "001X"};
    localparam int          T_CNT  [NV] = '{1, 1, 2, 2, 2, 3, 3, 3};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [W-1:0]  in_cube = '0;
    logic          res_valid, res_merged, res_reject;
    logic [IW-1:0] res_idx;
    logic [CW-1:0] count;
    logic          ovf;
    logic [IW-1:0] rd_idx = '0;
    logic [W-1:0]  rd_cube;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    cube_compactor #(.NPI(NPI), .DEPTH(DEPTH)) u_cube_compactor (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_cube(in_cube), .res_valid(res_valid), .res_merged(res_merged),
        .res_reject(res_reject), .res_idx(res_idx), .count(count), .ovf(ovf),
        .rd_idx(rd_idx), .rd_cube(rd_cube)
    );

    // first character is the highest position
    function automatic logic [W-1:0] enc(input logic [31:0] s);
        logic [W-1:0] r;
        r = '0;
        for (int i = 0; i < NPI; i++) begin
            if (s[8*i +: 8] == "0")      r[2*i +: 2] = 2'b10;
            else if (s[8*i +: 8] == "1") r[2*i +: 2] = 2'b11;
            else                         r[2*i +: 2] = 2'b00;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // send one cube, hold another cube valid while busy, return kind and latency
    task automatic send(input logic [W-1:0] c, output int lat, output bit busy_ok);
        @(negedge clk);
        in_cube  = c;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_cube = enc("1111");
        lat     = 0;
        busy_ok = 1'b1;
        while (!res_valid) begin
            if (in_ready) busy_ok = 1'b0;
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        if (in_ready) busy_ok = 1'b0;
        in_valid = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int  lat;
        bit  busy_ok;
        int  kind;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(count == 0, "R1 count", count, 0);
        check(ovf == 1'b0, "R1 ovf", ovf, 0);
        check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        check(res_valid == 1'b0, "R1 res_valid", res_valid, 0);
        rd_idx = 2'd0;
        #1;
        check(rd_cube == '0, "R1 slot empty", rd_cube, 0);

        for (int v = 0; v < NV; v++) begin
            send(enc(T_CUBE[v]), lat, busy_ok);
            kind = res_reject ? 2 : (res_merged ? 1 : 0);
            // R3 R4 R5 outcome kind
            check(kind == T_KIND[v], "R3/R4/R5 kind", kind, T_KIND[v]);
            if (T_KIND[v] != 2)
                check(res_idx == IW'(T_IDX[v]), "R3 R4 index", res_idx, T_IDX[v]);
            // R7 latency
            check(lat == T_LAT[v], "R7 latency", lat, T_LAT[v]);
            // R6 busy
            check(busy_ok, "R6 ready low while busy", busy_ok, 1);
            @(negedge clk);
            // R7 single pulse
            check(res_valid == 1'b0, "R7 one-cycle result", res_valid, 0);
            rd_idx = IW'(T_IDX[v]);
            #1;
            // R2 stored intersection, R8 readout
            check(rd_cube == enc(T_ENT[v]), "R2 R8 entry", rd_cube, enc(T_ENT[v]));
            check(count == CW'(T_CNT[v]), "R4 count", count, T_CNT[v]);
            // R5 sticky flag
            check(ovf == (v >= 6), "R5 ovf", ovf, (v >= 6));
        end

        // final table: held cube 1111 never entered (R6), refusal left entries intact (R5)
        rd_idx = 2'd0; #1;
        check(rd_cube == enc("0101"), "R5 entry0 final", rd_cube, enc("0101"));
        rd_idx = 2'd1; #1;
        check(rd_cube == enc("111X"), "R6 entry1 final", rd_cube, enc("111X"));
        rd_idx = 2'd2; #1;
        check(rd_cube == enc("001X"), "R2 entry2 final", rd_cube, enc("001X"));
        rd_idx = 2'd3; #1;
        check(rd_cube == '0, "R8 out-of-range slot", rd_cube, 0);
        check(count == 2'd3, "R6 count final", count, 3);

        // R6 valid low: nothing accepted
        @(negedge clk);
        in_cube = enc("0000");
        repeat (4) @(negedge clk);
        check(res_valid == 1'b0 && count == 2'd3, "R6 idle without valid", count, 3);

        // R1 reset clears table and flag
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_idx = 2'd0; #1;
        check(count == 0 && ovf == 1'b0, "R1 reset again", {count, ovf}, 0);
        check(rd_cube == '0, "R1 slot cleared", rd_cube, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule